// File: doc/BRIEF.md
# Task Execution-Time Watchdog Channel

This block times one real-time task. Software preloads an upper and a lower bound on the task's execution time. It then loads a 16-bit down counter, either directly or by copying the upper bound, and starts the count by setting the run bit of a 3-bit control register. The same register picks the counting tick: 1, 4, 16 or 64 microseconds. These ticks come from a free-running prescaler that turns the fast system clock into single-cycle enables.

If the counter runs down to zero, the channel raises an overrun request. The request stays up until software acknowledges it. When the task ends, software stops the count and reads the early-finish flag. That flag compares the time used so far (the upper bound minus the counter, plus one) against the lower bound. All registers can be read back on a shared data-out bus through separate output enables. The bus is zero unless exactly one enable is active, so several channels can be OR-combined.

A small state machine tracks the count: STOPPED (run bit clear), COUNTING (run bit set and counter nonzero) and EXPIRED (run bit set and counter at zero). It moves STOPPED→COUNTING or STOPPED→EXPIRED when the run bit is set, depending on the counter. It moves COUNTING→EXPIRED when a tick takes the counter from 1 to 0. It moves EXPIRED→COUNTING when a nonzero value is loaded. Any state goes to STOPPED when the run bit is cleared. The counter only decrements in COUNTING.

Top module: `task_exec_timer`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets the control register to 000 (stopped, tick code 0), the counter to 0xFFFF, both bounds to 0 and the overrun request to 0.
- R2: At a rising edge, ld_ctrl stores din[2:0] in the control register. Bit 2 is the run bit and bits 1:0 are the tick code. ld_limit_max stores din in the upper bound and ld_limit_min stores din in the lower bound.
- R3: At a rising edge, ld_count loads the counter from din and ld_count_max copies the upper bound into it. ld_count wins when both are high. Loads work whether or not the run bit is set.
- R4: dout shows one register, and only when exactly one of oe_ctrl, oe_count, oe_limit_max, oe_limit_min is high: the control register zero-extended on bits 2:0, the counter, the upper bound or the lower bound. With no enable, or more than one, dout is 0.
- R5: Rising edges are numbered from 1, counting the first edge with rst_n high. While the run bit is set and no load is active, the counter decrements at every edge whose number is a multiple of CLK_PER_US·4^code, where code is the tick code. With the run bit clear the counter holds.
- R6: The counter holds at zero and never wraps.
- R7: The overrun request rises at the edge where a tick takes the counter from 1 to 0. It stays high until an edge with ack high clears it; a set at the same edge beats the ack. Holding at zero or loading zero does not raise it.
- R8: early_finish is 1 when ((upper − counter + 1) mod 2^16) < lower, unsigned, and 0 otherwise. It follows the registers combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Write data |
| ld_ctrl | input | 1 | Load control register from din[2:0] |
| ld_count | input | 1 | Load counter from din |
| ld_count_max | input | 1 | Copy upper bound into counter |
| ld_limit_max | input | 1 | Load upper bound from din |
| ld_limit_min | input | 1 | Load lower bound from din |
| oe_ctrl | input | 1 | Read control register |
| oe_count | input | 1 | Read counter |
| oe_limit_max | input | 1 | Read upper bound |
| oe_limit_min | input | 1 | Read lower bound |
| ack | input | 1 | Acknowledge, clears overrun request |
| dout | output | 16 | Read data, zero when not selected |
| overrun_req | output | 1 | Sticky overrun request |
| early_finish | output | 1 | Elapsed time below lower bound |

## Verification
The properties are checked on every cycle. They cover the quiet bus when the enable count is not one, counter steps of at most one, holding while stopped or at zero, the match between EXPIRED and a zero counter, and the overrun request: it stays up, ack clears it, and it only rises on a 1-to-0 step. Only the bench scenarios can show the actual tick spacing for each rate code, load priority, the set-beats-ack collision, the 16-bit wrap in the early-finish comparison, and the reset values seen at the ports.

// File: rtl/tet_pkg.sv
package tet_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_COUNTING = 2'd1,
        ST_EXPIRED  = 2'd2
    } run_state_t;
endpackage

// File: rtl/tet_tick_gen.sv
module tet_tick_gen #(
    parameter int CLK_PER_US = 50,
    parameter int NUM_RATES  = 4,
    parameter int STEP_LOG2  = 2,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int US_W  = ((NUM_RATES - 1) * STEP_LOG2 > 0) ? (NUM_RATES - 1) * STEP_LOG2 : 1;

    logic [PRE_W-1:0]     pre_q;
    logic [US_W-1:0]      us_q;
    logic                 us_pulse;
    logic [NUM_RATES-1:0] rate_tick;

    assign us_pulse = (pre_q == PRE_W'(CLK_PER_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else begin
            pre_q <= us_pulse ? '0 : pre_q + 1'b1;
            if (us_pulse) us_q <= us_q + 1'b1;
        end
    end

    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
        if (r == 0) begin : g_base
            assign rate_tick[r] = us_pulse;
        end else begin : g_div
            assign rate_tick[r] = us_pulse && (&us_q[r*STEP_LOG2-1:0]);
        end
    end

    assign tick = rate_tick[rate_sel];
endmodule

// File: rtl/tet_counter.sv
module tet_counter
    import tet_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_next,
    input  logic              tick,
    input  logic              ld_din,
    input  logic              ld_max,
    input  logic              ack,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] max_val,
    output logic [DATA_W-1:0] count,
    output logic              overrun,
    output run_state_t        state
);
    run_state_t        st_q, st_d;
    logic [DATA_W-1:0] cnt_q, cnt_d;
    logic              ovr_q, ovr_d;
    logic              step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_STOPPED;
            cnt_q <= '1;
            ovr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ovr_q <= ovr_d;
        end
    end

    always_comb begin
        step = 1'b0;
        unique case (st_q)
            ST_COUNTING:            step = tick;
            ST_STOPPED, ST_EXPIRED: step = 1'b0;
            default:                step = 1'b0;
        endcase

        if (ld_din)      cnt_d = din;
        else if (ld_max) cnt_d = max_val;
        else if (step)   cnt_d = cnt_q - DATA_W'(1);
        else             cnt_d = cnt_q;

        ovr_d = ovr_q & ~ack;
        if (step && !ld_din && !ld_max && cnt_q == DATA_W'(1)) ovr_d = 1'b1;

        if (!run_next)          st_d = ST_STOPPED;
        else if (cnt_d == '0)   st_d = ST_EXPIRED;
        else                    st_d = ST_COUNTING;
    end

    always_comb begin
        count   = cnt_q;
        overrun = ovr_q;
        state   = st_q;
    end
endmodule

// File: rtl/tet_readout.sv
module tet_readout #(
    parameter int DATA_W = 16,
    parameter int CTRL_W = 3
) (
    input  logic [3:0]        oe,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [DATA_W-1:0] count,
    input  logic [DATA_W-1:0] max_v,
    input  logic [DATA_W-1:0] min_v,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        case (oe)
            4'b1000: dout = DATA_W'(ctrl);
            4'b0100: dout = count;
            4'b0010: dout = max_v;
            4'b0001: dout = min_v;
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/task_exec_timer.sv
module task_exec_timer
    import tet_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int CLK_PER_US     = 50,
    parameter int NUM_RATES      = 4,
    parameter int RATE_STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ld_ctrl,
    input  logic              ld_count,
    input  logic              ld_count_max,
    input  logic              ld_limit_max,
    input  logic              ld_limit_min,
    input  logic              oe_ctrl,
    input  logic              oe_count,
    input  logic              oe_limit_max,
    input  logic              oe_limit_min,
    input  logic              ack,
    output logic [DATA_W-1:0] dout,
    output logic              overrun_req,
    output logic              early_finish
);
    localparam int RATE_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1;
    localparam int CTRL_W = RATE_W + 1;

    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [DATA_W-1:0] lim_max_q, lim_min_q, cnt_w, elapsed;
    logic              tick_w, run_en_q;
    run_state_t        st_w;

    assign ctrl_d   = ld_ctrl ? din[CTRL_W-1:0] : ctrl_q;
    assign run_en_q = ctrl_q[CTRL_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            lim_max_q <= '0;
            lim_min_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (ld_limit_max) lim_max_q <= din;
            if (ld_limit_min) lim_min_q <= din;
        end
    end

    tet_tick_gen #(
        .CLK_PER_US(CLK_PER_US), .NUM_RATES(NUM_RATES),
        .STEP_LOG2(RATE_STEP_LOG2), .SEL_W(RATE_W)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .rate_sel(ctrl_q[RATE_W-1:0]), .tick(tick_w)
    );

    tet_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_next(ctrl_d[CTRL_W-1]), .tick(tick_w),
        .ld_din(ld_count), .ld_max(ld_count_max), .ack(ack), .din(din),
        .max_val(lim_max_q), .count(cnt_w), .overrun(overrun_req), .state(st_w)
    );

    tet_readout #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_rd (
        .oe({oe_ctrl, oe_count, oe_limit_max, oe_limit_min}), .ctrl(ctrl_q),
        .count(cnt_w), .max_v(lim_max_q), .min_v(lim_min_q), .dout(dout)
    );

    assign elapsed      = lim_max_q - cnt_w + DATA_W'(1);
    assign early_finish = (elapsed < lim_min_q);
endmodule

// File: rtl/tet_checker.sv
module tet_checker
    import tet_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_count,
    input logic              ld_count_max,
    input logic              ack,
    input logic [3:0]        oe,
    input logic [DATA_W-1:0] dout,
    input logic              overrun_req,
    input logic              run_en,
    input logic [DATA_W-1:0] cnt,
    input run_state_t        state
);
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(oe) != 1) |-> (dout == '0)); // R4
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !ld_count && !ld_count_max) |=> (cnt == $past(cnt))); // R5
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_count && !ld_count_max) |=> (cnt == $past(cnt) || cnt == $past(cnt) - DATA_W'(1))); // R5
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !ld_count && !ld_count_max) |=> (cnt == '0)); // R6
    AST_EXPIRED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRED) |-> (cnt == '0)); // R6
    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_req && !ack) |=> overrun_req); // R7
    AST_REQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && cnt != DATA_W'(1)) |=> !overrun_req); // R7
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_req) |-> (cnt == '0 && $past(cnt) == DATA_W'(1))); // R7
endmodule

bind task_exec_timer tet_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_count(ld_count), .ld_count_max(ld_count_max),
    .ack(ack), .oe({oe_ctrl, oe_count, oe_limit_max, oe_limit_min}), .dout(dout),
    .overrun_req(overrun_req), .run_en(run_en_q), .cnt(cnt_w), .state(st_w)
);

// File: tb/task_exec_timer_test.sv
`timescale 1ns/1ps
module task_exec_timer_test;
    localparam int P = 2;

    typedef struct packed {
        logic [4:0]  ld;   // ctrl, count, count_max, limit_max, limit_min
        logic [3:0]  oe;   // ctrl, count, limit_max, limit_min
        logic [15:0] din;
        logic [15:0] exp_dout;
        logic        exp_early;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{5'b00010, 4'b0010, 16'h0100, 16'h0100, 1'b0},
        '{5'b00001, 4'b0001, 16'h0200, 16'h0200, 1'b1},
        '{5'b01000, 4'b0100, 16'h0050, 16'h0050, 1'b1},
        '{5'b00100, 4'b0100, 16'h0000, 16'h0100, 1'b1},
        '{5'b01100, 4'b0100, 16'h0123, 16'h0123, 1'b0},
        '{5'b00001, 4'b0000, 16'h0000, 16'h0000, 1'b0},
        '{5'b10000, 4'b1000, 16'hFFF2, 16'h0002, 1'b0},
        '{5'b00000, 4'b1100, 16'h0000, 16'h0000, 1'b0},
        '{5'b00000, 4'b1111, 16'h0000, 16'h0000, 1'b0},
        '{5'b00001, 4'b0001, 16'hFFDF, 16'hFFDF, 1'b1},
        '{5'b00001, 4'b0001, 16'hFFDE, 16'hFFDE, 1'b0},
        '{5'b01000, 4'b0100, 16'h0001, 16'h0001, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] din = '0;
    logic ld_ctrl = 0, ld_count = 0, ld_count_max = 0, ld_limit_max = 0, ld_limit_min = 0;
    logic oe_ctrl = 0, oe_count = 0, oe_limit_max = 0, oe_limit_min = 0, ack = 0;
    logic [15:0] dout;
    logic overrun_req, early_finish;

    int vectors = 0, miscompares = 0, edge_idx = 0;
    int start_val = 0, start_edge = 0, run_rate = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) edge_idx <= 0;
        else        edge_idx <= edge_idx + 1;

    task_exec_timer #(.CLK_PER_US(P)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .ld_ctrl(ld_ctrl), .ld_count(ld_count),
        .ld_count_max(ld_count_max), .ld_limit_max(ld_limit_max), .ld_limit_min(ld_limit_min),
        .oe_ctrl(oe_ctrl), .oe_count(oe_count), .oe_limit_max(oe_limit_max),
        .oe_limit_min(oe_limit_min), .ack(ack), .dout(dout),
        .overrun_req(overrun_req), .early_finish(early_finish)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [3:0] sel, output logic [15:0] val);
        {oe_ctrl, oe_count, oe_limit_max, oe_limit_min} = sel;
        #1 val = dout;
        {oe_ctrl, oe_count, oe_limit_max, oe_limit_min} = 4'b0000;
    endtask

    task automatic strobe(input logic [4:0] ld, input logic [15:0] d, input logic a);
        @(negedge clk);
        {ld_ctrl, ld_count, ld_count_max, ld_limit_max, ld_limit_min} = ld;
        din = d; ack = a;
        @(negedge clk);
        {ld_ctrl, ld_count, ld_count_max, ld_limit_max, ld_limit_min} = 5'b0;
        ack = 1'b0;
    endtask

    function automatic int ticks(int lo, int hi, int per);
        return hi / per - lo / per;
    endfunction

    task automatic start_run(input int val, input logic [2:0] c);
        strobe(5'b10000, 16'h0000, 1'b0);
        strobe(5'b01000, 16'(val), 1'b1);
        strobe(5'b10000, {13'd0, c}, 1'b0);
        start_edge = edge_idx;
        start_val  = val;
        run_rate   = int'(c[1:0]);
    endtask

    task automatic check_run(input int wait_cycles, input string tag);
        logic [15:0] v;
        int n, e;
        repeat (wait_cycles) @(negedge clk);
        n = ticks(start_edge, edge_idx, P << (2 * run_rate));
        e = (n >= start_val) ? 0 : start_val - n;
        read_reg(4'b0100, v);
        chk({tag, " R5 count"}, v, 16'(e));
        chk({tag, " R7 overrun"}, {15'd0, overrun_req}, {15'd0, (start_val > 0 && n >= start_val)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++; miscompares++;
            $display("FAIL watchdog R5 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1: reset values seen at the ports
        read_reg(4'b0100, v); chk("R1 count", v, 16'hFFFF);
        read_reg(4'b1000, v); chk("R1 ctrl", v, 16'h0000);
        read_reg(4'b0010, v); chk("R1 upper", v, 16'h0000);
        read_reg(4'b0001, v); chk("R1 lower", v, 16'h0000);
        chk("R1 overrun", {15'd0, overrun_req}, 16'd0);
        chk("R1 early", {15'd0, early_finish}, 16'd0);
        rst_n = 1'b1;

        // R2 R3 R4 R8: load/readback table with the counter stopped
        foreach (VECS[i]) begin
            @(negedge clk);
            {ld_ctrl, ld_count, ld_count_max, ld_limit_max, ld_limit_min} = VECS[i].ld;
            {oe_ctrl, oe_count, oe_limit_max, oe_limit_min} = VECS[i].oe;
            din = VECS[i].din;
            @(negedge clk);
            {ld_ctrl, ld_count, ld_count_max, ld_limit_max, ld_limit_min} = 5'b0;
            #1;
            chk($sformatf("R2/R3/R4 vec%0d dout", i), dout, VECS[i].exp_dout);
            chk($sformatf("R8 vec%0d early", i), {15'd0, early_finish}, {15'd0, VECS[i].exp_early});
            chk($sformatf("R7 vec%0d no overrun", i), {15'd0, overrun_req}, 16'd0);
            {oe_ctrl, oe_count, oe_limit_max, oe_limit_min} = 4'b0000;
        end

        // R5 R6 R7: fastest tick, run to zero
        start_run(3, 3'b100);
        check_run(3, "rate0 early");
        check_run(10, "rate0 late");
        read_reg(4'b0100, v); chk("R6 held at zero", v, 16'h0000);
        chk("R8 early after run", {15'd0, early_finish}, 16'd1);

        // R7: ack clears, no re-raise while holding at zero
        strobe(5'b00000, 16'h0000, 1'b1);
        chk("R7 ack clears", {15'd0, overrun_req}, 16'd0);
        repeat (6) @(negedge clk);
        chk("R7 no re-raise at zero", {15'd0, overrun_req}, 16'd0);
        read_reg(4'b0100, v); chk("R6 still zero", v, 16'h0000);

        // R7: set beats ack at the same edge
        while ((edge_idx + 2) % P != 0) @(negedge clk);
        ld_count = 1'b1; din = 16'h0001;
        @(negedge clk);
        ld_count = 1'b0; ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R7 set beats ack", {15'd0, overrun_req}, 16'd1);
        read_reg(4'b0100, v); chk("R7 count at zero", v, 16'h0000);

        // R7: loading zero does not raise the request
        strobe(5'b00000, 16'h0000, 1'b1);
        strobe(5'b01000, 16'h0000, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7 zero load no request", {15'd0, overrun_req}, 16'd0);

        // R5: the other tick codes
        start_run(5, 3'b101);
        check_run(20, "rate1");
        start_run(4, 3'b110);
        check_run(70, "rate2");
        start_run(2, 3'b111);
        check_run(150, "rate3 mid");
        check_run(200, "rate3 end");

        // R5: stopped counter holds, R2 ctrl readback
        strobe(5'b10000, 16'h0003, 1'b1);
        strobe(5'b01000, 16'h0040, 1'b0);
        repeat (300) @(negedge clk);
        read_reg(4'b0100, v); chk("R5 stopped hold", v, 16'h0040);
        read_reg(4'b1000, v); chk("R2 ctrl readback", v, 16'h0003);

        // R3: copy of upper bound while running
        start_run(9, 3'b100);
        strobe(5'b00100, 16'h0000, 1'b0);
        read_reg(4'b0100, v); chk("R3 copy upper", v, 16'h0100);

        // R1: reset in the middle of a run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        read_reg(4'b0100, v); chk("R1 reset count", v, 16'hFFFF);
        read_reg(4'b1000, v); chk("R1 reset ctrl", v, 16'h0000);
        read_reg(4'b0001, v); chk("R1 reset lower", v, 16'h0000);
        chk("R1 reset overrun", {15'd0, overrun_req}, 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule